// File: doc/BRIEF.md
# Keyed Watchdog Timer with Reset Pulse Output

This block is the watchdog of a small 8-bit controller core. After any reset it sits disarmed and does not count. Software arms it by writing a two-byte key to a write-only service register on the special-function write bus. Once armed, it cannot be switched off by software. A wide counter then advances on every machine-cycle tick, and software must write the same key again before the counter runs past its top value. If software fails to do so, the block raises a device reset request and, unless the reset pin is configured as input-only, drives the reset pin high. The pulse lasts a fixed number of oscillator clocks. When the pulse ends, the watchdog is disarmed again.

The block runs on the oscillator clock. The machine-cycle tick is a one-clock strobe from the core's clock divider. Two low-power inputs decide when counting is suspended. Idle mode suspends counting only when the idle-freeze control is set. Power-down always suspends counting. After power-down is left through the external wake interrupt, counting stays suspended for as long as the wake line is still low.

The write bus is a plain strobe bus with no valid/ready handshake and no back-pressure. Every write strobe is taken in the clock cycle it is presented, and the block never stalls the bus.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, `wdt_reset_o` and `rst_out_o` are 0. While disarmed, the watchdog never produces a reset pulse, however long it runs.
- R2: The watchdog is armed by a write of 0x1E to address 0xA6 followed by a write of 0xE1 as the next write to 0xA6. A write of any other value to 0xA6 in between cancels the partial key. A write to any other address leaves the partial key intact.
- R3: Once armed, the counter (width 14) advances on each clock with `mc_tick`=1. The reset pulse begins on the 16384th counted tick after arming, which is the tick past 0x3FFF. With `mc_tick` high every clock, `wdt_reset_o` is first seen high 16384 clocks after the clock that accepted the arming write.
- R4: While armed, the same two-byte key clears the counter, so the next pulse starts 16384 counted ticks after the clock that accepted the final key write.
- R5: A timeout holds `wdt_reset_o` high for exactly 98 consecutive clocks. The counter does not advance during the pulse.
- R6: When the pulse ends, the watchdog is disarmed and produces no further pulse until it is armed again.
- R7: With `idle_mode`=1, ticks are counted if `idle_freeze`=0 and not counted if `idle_freeze`=1. Counting resumes when idle ends.
- R8: No tick is counted while `pdown_mode`=1. After `pdown_mode` falls, ticks stay uncounted while `wake_n`=0 and resume once `wake_n`=1. When no power-down has occurred, `wake_n` has no effect.
- R9: `rst_out_o` equals `wdt_reset_o` when `pin_passive`=0 and stays 0 when `pin_passive`=1. `wdt_reset_o` pulses in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Hardware reset, active low |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| sfr_wr | input | 1 | Write strobe of the special-function bus |
| sfr_addr | input | 8 | Write address |
| sfr_wdata | input | 8 | Write data |
| idle_freeze | input | 1 | 1: counter holds during idle |
| pin_passive | input | 1 | 1: reset pin is input only, never driven |
| idle_mode | input | 1 | Core is in idle |
| pdown_mode | input | 1 | Core is in power-down |
| wake_n | input | 1 | External wake interrupt level, active low |
| wdt_reset_o | output | 1 | Internal device reset request during the pulse |
| rst_out_o | output | 1 | Reset pin drive, high during the pulse when the pin is not passive |

## Verification
The hardest situations to reach are those that depend on the full 16384-tick overflow window combined with suspended counting. The critical one is the interval after power-down ends while the wake line is still low. The stimulus arms or services the watchdog and then opens windows of known length: idle with and without freeze, power-down, power-down followed by a low wake line, a low wake line with no power-down, and a halved tick rate. It then predicts the exact clock on which the pulse should rise, shifted by the number of gated ticks. If any gate is off by a single cycle, the rising edge moves and the prediction no longer matches.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  typedef enum logic {
    KEY_IDLE = 1'b0,
    KEY_HALF = 1'b1
  } key_st_e;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_keyed_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  SVC_ADDR = 8'hA6,
  parameter logic [7:0]  KEY_A    = 8'h1E,
  parameter logic [7:0]  KEY_B    = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              key_done
);
  localparam logic [ADDR_W-1:0] SVC_A = ADDR_W'(SVC_ADDR);
  localparam logic [DATA_W-1:0] K_A   = DATA_W'(KEY_A);
  localparam logic [DATA_W-1:0] K_B   = DATA_W'(KEY_B);

  key_st_e st_q, st_d;
  logic    hit;

  assign hit      = wr && (addr == SVC_A);
  assign key_done = hit && (st_q == KEY_HALF) && (wdata == K_B);

  always_comb begin
    st_d = st_q;
    if (hit) begin
      if (wdata == K_A) st_d = KEY_HALF;
      else              st_d = KEY_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KEY_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wdt_cycle_cnt.sv
module wdt_cycle_cnt #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ok,
  input  logic             key_done,
  input  logic             pulsing,
  input  logic             disarm,
  output logic             armed,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic inc;

  assign inc = armed && tick_ok && !pulsing;
  assign ovf = inc && !key_done && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (disarm) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (key_done && !pulsing) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int PULSE_LEN = 98
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic last
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);

  logic [PW-1:0] left_q;

  assign active = (left_q != '0);
  assign last   = (left_q == PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (start)   left_q <= LEN;
    else if (active)  left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter int         CNT_W     = 14,
  parameter int         PULSE_LEN = 98,
  parameter logic [7:0] SVC_ADDR  = 8'hA6,
  parameter logic [7:0] KEY_A     = 8'h1E,
  parameter logic [7:0] KEY_B     = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic              sfr_wr,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              idle_freeze,
  input  logic              pin_passive,
  input  logic              idle_mode,
  input  logic              pdown_mode,
  input  logic              wake_n,
  output logic              wdt_reset_o,
  output logic              rst_out_o
);
  logic             key_done;
  logic             armed;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf;
  logic             pulsing;
  logic             pulse_last;
  logic             wake_hold_q;
  logic             suspend;
  logic             tick_ok;

  // Counting stays suspended after power-down until the wake line is released.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wake_hold_q <= 1'b0;
    else if (pdown_mode) wake_hold_q <= 1'b1;
    else if (wake_n)     wake_hold_q <= 1'b0;
  end

  assign suspend = pdown_mode || (wake_hold_q && !wake_n) || (idle_mode && idle_freeze);
  assign tick_ok = mc_tick && !suspend;

  wdt_key_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SVC_ADDR(SVC_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) key_i (
    .clk(clk), .rst_n(rst_n), .wr(sfr_wr), .addr(sfr_addr),
    .wdata(sfr_wdata), .key_done(key_done)
  );

  wdt_cycle_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick_ok(tick_ok), .key_done(key_done),
    .pulsing(pulsing), .disarm(pulse_last), .armed(armed), .cnt(cnt_q), .ovf(ovf)
  );

  wdt_pulse_gen #(.PULSE_LEN(PULSE_LEN)) pulse_i (
    .clk(clk), .rst_n(rst_n), .start(ovf), .active(pulsing), .last(pulse_last)
  );

  assign wdt_reset_o = pulsing;
  assign rst_out_o   = pulsing && !pin_passive;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pdown_mode,
  input logic             pin_passive,
  input logic             wdt_reset_o,
  input logic             rst_out_o,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic             key_done
);
  AST_DISARMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (cnt == '0)); // R1

  AST_ARM_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(key_done)); // R2

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + 1'b1) || (cnt == '0))); // R3

  AST_PULSE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_o |-> (cnt == '0)); // R5

  AST_PDOWN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown_mode && !key_done) |=> $stable(cnt)); // R8

  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out_o |-> (wdt_reset_o && !pin_passive)); // R9

  AST_PIN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_reset_o && !pin_passive) |-> rst_out_o); // R9
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pdown_mode(pdown_mode), .pin_passive(pin_passive),
  .wdt_reset_o(wdt_reset_o), .rst_out_o(rst_out_o), .armed(armed),
  .cnt(cnt_q), .key_done(key_done)
);

// File: tb/wdt_keyed_tb_top.sv
`timescale 1ns/1ps
module wdt_keyed_tb_top;
  localparam int WIN  = 16384;
  localparam int PLEN = 98;

  typedef struct {
    int    at;
    logic  pin;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc_tick = 1'b1;
  logic sfr_wr = 1'b0;
  logic [7:0] sfr_addr = '0;
  logic [7:0] sfr_wdata = '0;
  logic idle_freeze = 1'b0, pin_passive = 1'b0, idle_mode = 1'b0;
  logic pdown_mode = 1'b0, wake_n = 1'b1;
  logic wdt_reset_o, rst_out_o;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_keyed dut_i (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .sfr_wr(sfr_wr),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .idle_freeze(idle_freeze),
    .pin_passive(pin_passive), .idle_mode(idle_mode), .pdown_mode(pdown_mode),
    .wake_n(wake_n), .wdt_reset_o(wdt_reset_o), .rst_out_o(rst_out_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  // Driver: write the key and queue the expected pulse, shifted by gated ticks.
  task automatic key_and_expect(input int shift, input logic pin, input string req);
    exp_t e;
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
    e.at = cyc + WIN + shift; e.pin = pin; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_pulse_done();
    while (exp_q.size() != 0) @(negedge clk);
    while (wdt_reset_o) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pop an expected pulse at each rising edge and compare.
  initial begin : monitor
    logic prev = 1'b0;
    int   width = 0;
    bit   pin_bad = 1'b0;
    exp_t cur;
    cur.at = 0; cur.pin = 1'b1; cur.req = "R6";
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (wdt_reset_o && !prev) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected pulse (R1)", 1, 0);
            cur.at = cyc; cur.pin = ~pin_passive; cur.req = "R6";
          end else begin
            cur = exp_q.pop_front();
            chk(cyc == cur.at, {cur.req, " pulse start cycle"}, cyc, cur.at);
          end
          width = 0; pin_bad = 1'b0;
        end
        if (wdt_reset_o) begin
          width++;
          if (rst_out_o !== cur.pin) pin_bad = 1'b1;
        end
        if (!wdt_reset_o && prev) begin
          chk(width == PLEN, "R5 pulse width", width, PLEN);
          chk(!pin_bad, "R9 reset pin level", int'(!pin_bad), 1);
        end
        prev = wdt_reset_o;
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 190000);
    finish_run();
  end

  initial begin : stim
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wdt_reset_o == 1'b0, "R1 reset request after reset", wdt_reset_o, 0);
    chk(rst_out_o == 1'b0, "R1 reset pin after reset", rst_out_o, 0);
    repeat (3000) @(negedge clk);
    chk(wdt_reset_o == 1'b0, "R1 no pulse while disarmed", wdt_reset_o, 0);

    // R2: broken key does not arm; foreign address does not break the key
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'h55);
    wr(8'hA6, 8'hE1);
    wr(8'hA6, 8'h1E);
    wr(8'h10, 8'h00);
    begin
      exp_t e;
      wr(8'hA6, 8'hE1);
      e.at = cyc + WIN; e.pin = 1'b1; e.req = "R2 R3";
      exp_q.push_back(e);
    end
    wait_pulse_done();
    // R6: disarmed after pulse, monitor flags any extra pulse
    repeat (17000) @(negedge clk);
    chk(wdt_reset_o == 1'b0, "R6 quiet after pulse", wdt_reset_o, 0);

    // R4: service clears the counter
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
    repeat (10000) @(negedge clk);
    key_and_expect(0, 1'b1, "R4");
    wait_pulse_done();

    // R7: idle without freeze counts, idle with freeze holds
    key_and_expect(2000, 1'b1, "R7");
    idle_mode = 1'b1;
    repeat (1000) @(negedge clk);
    idle_freeze = 1'b1;
    repeat (2000) @(negedge clk);
    idle_mode = 1'b0; idle_freeze = 1'b0;
    wait_pulse_done();

    // R8: power-down, then wake line low, then wake line low without power-down
    key_and_expect(800, 1'b1, "R8");
    pdown_mode = 1'b1;
    repeat (500) @(negedge clk);
    pdown_mode = 1'b0; wake_n = 1'b0;
    repeat (300) @(negedge clk);
    wake_n = 1'b1;
    repeat (50) @(negedge clk);
    wake_n = 1'b0;
    repeat (200) @(negedge clk);
    wake_n = 1'b1;
    wait_pulse_done();

    // R9: passive pin stays low, request still pulses
    pin_passive = 1'b1;
    key_and_expect(0, 1'b0, "R9");
    wait_pulse_done();
    pin_passive = 1'b0;

    // R3: only ticks are counted (half rate for 4000 clocks)
    key_and_expect(2000, 1'b1, "R3 tick");
    for (int i = 0; i < 4000; i++) begin
      mc_tick = i[0];
      @(negedge clk);
    end
    mc_tick = 1'b1;
    wait_pulse_done();

    chk(exp_q.size() == 0, "R3 all pulses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule